// File: doc/BRIEF.md
# Two-Tier Level Interrupt Controller

This block collects 64 peripheral interrupt lines and 8 local interrupt lines, all level-sensitive, and turns them into a single maskable IRQ request and a single fast-interrupt (FIQ) request for one processor. Software uses a simple 32-bit register bus to do three things. It sets and clears per-source enable bits through separate write-1-to-set and write-1-to-clear registers. It reads the masked pending state, either per group or through a summary word with shortcut bits. It routes any one raw source to the FIQ output.

The IRQ output is the OR of every enabled and active source. The FIQ output follows the raw level of the one selected source and does not look at the IRQ enable masks. Both outputs are registered, so each one reflects the inputs and register state sampled on the previous clock edge. Read data is combinational from the current state. A read strobe is a cycle with `bus_sel_i` high and `bus_wr_i` low. A write is taken on the clock edge that ends a cycle with both high. Register selection is done by a decoded access state. The states are SUMMARY, PEND_LO, PEND_HI, FIQ_CTRL, EN_LO, EN_HI, EN_LOC, DIS_LO, DIS_HI, DIS_LOC and NONE. The state is chosen fresh on every access and carries no history.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Writing offset 0x10, 0x14 or 0x18 sets the enable bits of peripheral sources 0–31, peripheral sources 32–63 or local sources 0–7 (write data bits 7:0) where the written bit is 1. Written 0 bits leave the mask as it was. Reading these offsets returns the mask, zero-extended.
- R2: Writing offset 0x1C, 0x20 or 0x24 clears the enable bits of the same three groups, in the same order, where the written bit is 1. Written 0 bits leave the mask unchanged.
- R3: Offset 0x04 reads the peripheral levels 31:0 ANDed with their enables. Offset 0x08 reads the same for peripheral sources 63:32.
- R4: Offset 0x00 reads the summary word, with all fields masked by the enables. Bits 7:0 are the masked local sources. Bit 8 is set when any masked peripheral source 0–31 is active, and bit 9 when any masked source 32–63 is. Bits 10 to 20 carry masked peripheral sources 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order. Bits 31:21 read 0.
- R5: Offsets 0x1C, 0x20 and 0x24 read the bitwise inverse of the corresponding zero-extended 32-bit enable mask, so bits 31:8 of 0x24 read 1.
- R6: At offset 0x0C, write bits 6:0 set the FIQ source select and bit 7 the FIQ enable. A read returns the enable in bit 7, the select in bits 6:0 and 0 above.
- R7: With the FIQ enabled, the FIQ output equals the raw level of the selected source regardless of any enable mask. Select values 0–63 pick a peripheral source, 64–71 pick local source (select − 64), and 72–127 give 0. With the FIQ disabled the output is 0.
- R8: The IRQ output is 1 exactly when some source is both active and enabled.
- R9: Both outputs are registered. A change to an input or register shows at the outputs one clock edge after it takes effect.
- R10: Reset clears all enable masks, disables the FIQ and sets its select to 0, so both outputs are 0.
- R11: Reads of any other offset, including offsets that are not word-aligned, return 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_lvl_i | input | 64 | Peripheral interrupt levels |
| local_lvl_i | input | 8 | Local interrupt levels |
| bus_sel_i | input | 1 | Bus access valid |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 9 | Byte offset in the 512-byte window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (0 when not reading) |
| irq_o | output | 1 | Registered maskable interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The bench builds the block with its default parameters: 64 peripheral and 8 local sources and a 9-bit offset. With these values every FIQ select code from 0 to 127 is reachable, including the local range and the dead range above it. Every offset in the window can be hit, including unaligned ones and the undefined words above 0x24. The 7-bit select and the fixed mirror positions in the summary word are exercised exactly as a processor would see them.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned SEL_W      = 7;
    localparam int unsigned NUM_MIRROR = 11;

    // Decoded access state: one per register word, NONE for holes.
    typedef enum logic [3:0] {
        RS_SUMMARY,
        RS_PEND_LO,
        RS_PEND_HI,
        RS_FIQ_CTRL,
        RS_EN_LO,
        RS_EN_HI,
        RS_EN_LOC,
        RS_DIS_LO,
        RS_DIS_HI,
        RS_DIS_LOC,
        RS_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_word(input int unsigned widx);
        reg_sel_e r;
        case (widx)
            0:       r = RS_SUMMARY;
            1:       r = RS_PEND_LO;
            2:       r = RS_PEND_HI;
            3:       r = RS_FIQ_CTRL;
            4:       r = RS_EN_LO;
            5:       r = RS_EN_HI;
            6:       r = RS_EN_LOC;
            7:       r = RS_DIS_LO;
            8:       r = RS_DIS_HI;
            9:       r = RS_DIS_LOC;
            default: r = RS_NONE;
        endcase
        return r;
    endfunction

    // Peripheral source mirrored at summary bit (group bits + k).
    function automatic int unsigned mirror_src(input int unsigned k);
        int unsigned s;
        case (k)
            0:       s = 7;
            1:       s = 9;
            2:       s = 10;
            3:       s = 18;
            4:       s = 19;
            5:       s = 53;
            6:       s = 54;
            7:       s = 55;
            8:       s = 56;
            9:       s = 57;
            default: s = 62;
        endcase
        return s;
    endfunction

    function automatic reg_sel_e half_en_sel(input int unsigned h);
        return (h == 0) ? RS_EN_LO : RS_EN_HI;
    endfunction

    function automatic reg_sel_e half_dis_sel(input int unsigned h);
        return (h == 0) ? RS_DIS_LO : RS_DIS_HI;
    endfunction

endpackage

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 64,
    parameter int unsigned NUM_LOCAL  = 8,
    parameter int unsigned ADDR_W     = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel_i,
    input  logic                  bus_wr_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [WORD_W-1:0]     bus_wdata_i,
    output reg_sel_e              acc_sel_o,
    output logic                  rd_stb_o,
    output logic [NUM_PERIPH-1:0] pen_o,
    output logic [NUM_LOCAL-1:0]  len_o,
    output logic                  fen_o,
    output logic [SEL_W-1:0]      fsel_o
);

    localparam int unsigned HALVES = NUM_PERIPH / WORD_W;

    reg_sel_e              acc_sel;
    logic                  wr_stb;
    logic [NUM_PERIPH-1:0] pen_q, pen_d;
    logic [NUM_LOCAL-1:0]  len_q, len_d;
    logic                  fen_q, fen_d;
    logic [SEL_W-1:0]      fsel_q, fsel_d;

    // Access decode: unaligned offsets fall into NONE.
    always_comb begin
        if (bus_addr_i[1:0] != 2'b00) begin
            acc_sel = RS_NONE;
        end else begin
            acc_sel = decode_word(int'(bus_addr_i[ADDR_W-1:2]));
        end
    end

    assign wr_stb   = bus_sel_i && bus_wr_i;
    assign rd_stb_o = bus_sel_i && !bus_wr_i;
    assign acc_sel_o = acc_sel;

    // Next-state for the peripheral masks, one word per half.
    always_comb begin
        pen_d = pen_q;
        if (wr_stb) begin
            for (int unsigned h = 0; h < HALVES; h++) begin
                if (acc_sel == half_en_sel(h)) begin
                    pen_d[h*WORD_W +: WORD_W] = pen_q[h*WORD_W +: WORD_W] | bus_wdata_i;
                end
                if (acc_sel == half_dis_sel(h)) begin
                    pen_d[h*WORD_W +: WORD_W] = pen_q[h*WORD_W +: WORD_W] & ~bus_wdata_i;
                end
            end
        end
    end

    // Next-state for the local mask and FIQ control.
    always_comb begin
        len_d  = len_q;
        fen_d  = fen_q;
        fsel_d = fsel_q;
        if (wr_stb) begin
            unique case (acc_sel)
                RS_EN_LOC:   len_d = len_q | bus_wdata_i[NUM_LOCAL-1:0];
                RS_DIS_LOC:  len_d = len_q & ~bus_wdata_i[NUM_LOCAL-1:0];
                RS_FIQ_CTRL: begin
                    fsel_d = bus_wdata_i[SEL_W-1:0];
                    fen_d  = bus_wdata_i[SEL_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pen_q  <= '0;
            len_q  <= '0;
            fen_q  <= 1'b0;
            fsel_q <= '0;
        end else begin
            pen_q  <= pen_d;
            len_q  <= len_d;
            fen_q  <= fen_d;
            fsel_q <= fsel_d;
        end
    end

    assign pen_o  = pen_q;
    assign len_o  = len_q;
    assign fen_o  = fen_q;
    assign fsel_o = fsel_q;

    // R1: a set-enable write leaves every written 1 set.
    p_en_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_sel == RS_EN_LO) |=>
            ((pen_q[WORD_W-1:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R2: a clear-enable write leaves every written 1 clear.
    p_dis_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_sel == RS_DIS_HI) |=>
            ((pen_q[NUM_PERIPH-1:NUM_PERIPH-WORD_W] & $past(bus_wdata_i)) == '0));

    // R11: writes to holes change nothing.
    p_hole_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_sel == RS_NONE) |=>
            ($stable(pen_q) && $stable(len_q) && $stable(fen_q) && $stable(fsel_q)));

    // R10: state right after reset release is all clear.
    p_reset_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pen_q == '0 && len_q == '0 && !fen_q && fsel_q == '0));

endmodule

// File: rtl/lvl_irq_readmux.sv
module lvl_irq_readmux
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 64,
    parameter int unsigned NUM_LOCAL  = 8
) (
    input  logic [NUM_PERIPH-1:0] periph_lvl_i,
    input  logic [NUM_LOCAL-1:0]  local_lvl_i,
    input  logic [NUM_PERIPH-1:0] pen_i,
    input  logic [NUM_LOCAL-1:0]  len_i,
    input  logic                  fen_i,
    input  logic [SEL_W-1:0]      fsel_i,
    input  reg_sel_e              acc_sel_i,
    input  logic                  rd_stb_i,
    output logic [WORD_W-1:0]     rdata_o,
    output logic                  irq_req_o
);

    localparam int unsigned HALVES   = NUM_PERIPH / WORD_W;
    localparam int unsigned GRP_BASE = NUM_LOCAL;
    localparam int unsigned MIR_BASE = NUM_LOCAL + HALVES;

    logic [NUM_PERIPH-1:0] ppend;
    logic [NUM_LOCAL-1:0]  lpend;
    logic [WORD_W-1:0]     summary;
    logic [WORD_W-1:0]     rsel;

    assign ppend = periph_lvl_i & pen_i;
    assign lpend = local_lvl_i & len_i;
    assign irq_req_o = (|ppend) || (|lpend);

    always_comb begin
        summary = '0;
        summary[NUM_LOCAL-1:0] = lpend;
        for (int unsigned h = 0; h < HALVES; h++) begin
            summary[GRP_BASE + h] = |ppend[h*WORD_W +: WORD_W];
        end
        for (int unsigned k = 0; k < NUM_MIRROR; k++) begin
            summary[MIR_BASE + k] = ppend[mirror_src(k)];
        end
    end

    always_comb begin
        unique case (acc_sel_i)
            RS_SUMMARY:  rsel = summary;
            RS_PEND_LO:  rsel = ppend[WORD_W-1:0];
            RS_PEND_HI:  rsel = ppend[NUM_PERIPH-1:NUM_PERIPH-WORD_W];
            RS_FIQ_CTRL: rsel = WORD_W'({fen_i, fsel_i});
            RS_EN_LO:    rsel = pen_i[WORD_W-1:0];
            RS_EN_HI:    rsel = pen_i[NUM_PERIPH-1:NUM_PERIPH-WORD_W];
            RS_EN_LOC:   rsel = WORD_W'(len_i);
            RS_DIS_LO:   rsel = ~pen_i[WORD_W-1:0];
            RS_DIS_HI:   rsel = ~pen_i[NUM_PERIPH-1:NUM_PERIPH-WORD_W];
            RS_DIS_LOC:  rsel = ~WORD_W'(len_i);
            default:     rsel = '0;
        endcase
    end

    assign rdata_o = rd_stb_i ? rsel : '0;

    // R5: the local clear-enable view always reads 1 above the mask.
    always_comb begin
        if (rd_stb_i && acc_sel_i == RS_DIS_LOC) begin
            a_dis_loc_upper_r5: assert (rdata_o[WORD_W-1:NUM_LOCAL] == '1);
        end
    end

endmodule

// File: rtl/lvl_irq_out.sv
module lvl_irq_out
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 64,
    parameter int unsigned NUM_LOCAL  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] periph_lvl_i,
    input  logic [NUM_LOCAL-1:0]  local_lvl_i,
    input  logic                  fen_i,
    input  logic [SEL_W-1:0]      fsel_i,
    input  logic                  irq_req_i,
    output logic                  irq_o,
    output logic                  fiq_o
);

    logic fiq_pick;

    // Raw source select; codes past the local range match nothing.
    always_comb begin
        fiq_pick = 1'b0;
        if (fen_i) begin
            for (int unsigned i = 0; i < NUM_PERIPH; i++) begin
                if (fsel_i == SEL_W'(i)) fiq_pick = periph_lvl_i[i];
            end
            for (int unsigned j = 0; j < NUM_LOCAL; j++) begin
                if (fsel_i == SEL_W'(NUM_PERIPH + j)) fiq_pick = local_lvl_i[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= irq_req_i;
            fiq_o <= fiq_pick;
        end
    end

    // R7: a disabled FIQ keeps the output low on the next edge.
    p_fiq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fen_i |=> !fiq_o);

    // R7: select codes above the local range give a low output.
    p_fiq_dead_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel_i >= SEL_W'(NUM_PERIPH + NUM_LOCAL)) |=> !fiq_o);

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 64,
    parameter int unsigned NUM_LOCAL  = 8,
    parameter int unsigned ADDR_W     = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] periph_lvl_i,
    input  logic [NUM_LOCAL-1:0]  local_lvl_i,
    input  logic                  bus_sel_i,
    input  logic                  bus_wr_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [WORD_W-1:0]     bus_wdata_i,
    output logic [WORD_W-1:0]     bus_rdata_o,
    output logic                  irq_o,
    output logic                  fiq_o
);

    localparam int unsigned PIDX_W = $clog2(NUM_PERIPH);

    reg_sel_e              acc_sel;
    logic                  rd_stb;
    logic [NUM_PERIPH-1:0] pen;
    logic [NUM_LOCAL-1:0]  len;
    logic                  fen;
    logic [SEL_W-1:0]      fsel;
    logic                  irq_req;

    lvl_irq_regs #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_LOCAL  (NUM_LOCAL),
        .ADDR_W     (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .acc_sel_o   (acc_sel),
        .rd_stb_o    (rd_stb),
        .pen_o       (pen),
        .len_o       (len),
        .fen_o       (fen),
        .fsel_o      (fsel)
    );

    lvl_irq_readmux #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_LOCAL  (NUM_LOCAL)
    ) u_readmux (
        .periph_lvl_i (periph_lvl_i),
        .local_lvl_i  (local_lvl_i),
        .pen_i        (pen),
        .len_i        (len),
        .fen_i        (fen),
        .fsel_i       (fsel),
        .acc_sel_i    (acc_sel),
        .rd_stb_i     (rd_stb),
        .rdata_o      (bus_rdata_o),
        .irq_req_o    (irq_req)
    );

    lvl_irq_out #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_LOCAL  (NUM_LOCAL)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .periph_lvl_i (periph_lvl_i),
        .local_lvl_i  (local_lvl_i),
        .fen_i        (fen),
        .fsel_i       (fsel),
        .irq_req_i    (irq_req),
        .irq_o        (irq_o),
        .fiq_o        (fiq_o)
    );

    // R8: nothing active and enabled means no IRQ on the next edge.
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (((periph_lvl_i & pen) == '0) && ((local_lvl_i & len) == '0)) |=> !irq_o);

    // R7: an enabled FIQ on a peripheral code tracks the raw line.
    p_fiq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fen && fsel < SEL_W'(NUM_PERIPH)) |=>
            (fiq_o == $past(periph_lvl_i[fsel[PIDX_W-1:0]])));

endmodule

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 64;
    localparam int NL = 8;
    localparam int MIR [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] plvl = '0;
    logic [7:0]  llvl = '0;
    logic        bsel = 1'b0;
    logic        bwr = 1'b0;
    logic [8:0]  baddr = '0;
    logic [31:0] bwdata = '0;
    logic [31:0] brdata;
    logic        irq, fiq;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [63:0] m_pen = '0;
    logic [7:0]  m_len = '0;
    logic        m_fen = 1'b0;
    logic [6:0]  m_fsel = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_irq_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .periph_lvl_i (plvl),
        .local_lvl_i  (llvl),
        .bus_sel_i    (bsel),
        .bus_wr_i     (bwr),
        .bus_addr_i   (baddr),
        .bus_wdata_i  (bwdata),
        .bus_rdata_o  (brdata),
        .irq_o        (irq),
        .fiq_o        (fiq)
    );

    function automatic logic [31:0] exp_summary();
        logic [63:0] p = plvl & m_pen;
        logic [31:0] s = '0;
        s[7:0] = llvl & m_len;
        s[8] = |p[31:0];
        s[9] = |p[63:32];
        for (int k = 0; k < 11; k++) s[10+k] = p[MIR[k]];
        return s;
    endfunction

    function automatic logic [31:0] exp_read(input logic [8:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a)
            9'h00: return exp_summary();
            9'h04: return (plvl[31:0] & m_pen[31:0]);
            9'h08: return (plvl[63:32] & m_pen[63:32]);
            9'h0C: return {24'h0, m_fen, m_fsel};
            9'h10: return m_pen[31:0];
            9'h14: return m_pen[63:32];
            9'h18: return {24'h0, m_len};
            9'h1C: return ~m_pen[31:0];
            9'h20: return ~m_pen[63:32];
            9'h24: return ~{24'h0, m_len};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [8:0] a);
        if (a[1:0] != 2'b00) return "R11";
        case (a)
            9'h00: return "R4";
            9'h04, 9'h08: return "R3";
            9'h0C: return "R6";
            9'h10, 9'h14, 9'h18: return "R1";
            9'h1C, 9'h20, 9'h24: return "R5";
            default: return "R11";
        endcase
    endfunction

    function automatic logic exp_irq();
        return ((plvl & m_pen) != '0) || ((llvl & m_len) != '0);
    endfunction

    function automatic logic exp_fiq();
        if (!m_fen) return 1'b0;
        if (m_fsel < 7'd64) return plvl[m_fsel[5:0]];
        if (m_fsel < 7'd72) return llvl[m_fsel[2:0]];
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [8:0] a, input logic [31:0] d);
        if (a[1:0] == 2'b00) begin
            case (a)
                9'h0C: begin m_fsel = d[6:0]; m_fen = d[7]; end
                9'h10: m_pen[31:0]  = m_pen[31:0] | d;
                9'h14: m_pen[63:32] = m_pen[63:32] | d;
                9'h18: m_len        = m_len | d[7:0];
                9'h1C: m_pen[31:0]  = m_pen[31:0] & ~d;
                9'h20: m_pen[63:32] = m_pen[63:32] & ~d;
                9'h24: m_len        = m_len & ~d[7:0];
                default: ;
            endcase
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bsel = 1'b1; bwr = 1'b1; baddr = a; bwdata = d;
        @(negedge clk);
        bsel = 1'b0; bwr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input logic [8:0] a, input string tag);
        @(negedge clk);
        bsel = 1'b1; bwr = 1'b0; baddr = a;
        #1;
        chk(tag, brdata, exp_read(a));
        bsel = 1'b0;
    endtask

    task automatic check_all_regs();
        for (int i = 0; i < 10; i++) rd_chk(9'(i * 4), req_of(9'(i * 4)));
    endtask

    task automatic check_outputs(input string tag);
        @(negedge clk);
        @(negedge clk);
        chk({tag, " R8 irq"}, {31'h0, irq}, {31'h0, exp_irq()});
        chk({tag, " R7 fiq"}, {31'h0, fiq}, {31'h0, exp_fiq()});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [8:0] a;
        logic [31:0] d;
        void'($urandom(32'd20240611));

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 irq in reset", {31'h0, irq}, 32'h0);
        chk("R10 fiq in reset", {31'h0, fiq}, 32'h0);
        rst_n = 1'b1;
        rd_chk(9'h10, "R10 en lo");
        rd_chk(9'h18, "R10 en loc");
        rd_chk(9'h24, "R10 dis loc");
        rd_chk(9'h0C, "R10 fiq ctrl");

        // R1: set-only enables accumulate
        bus_write(9'h10, 32'h0000_0681);
        bus_write(9'h10, 32'h8004_0000);
        rd_chk(9'h10, "R1 union lo");
        bus_write(9'h14, 32'h43E0_0000);
        bus_write(9'h18, 32'hFFFF_FF05);
        rd_chk(9'h14, "R1 hi");
        rd_chk(9'h18, "R1 loc upper bits dropped");

        // R2: clear-only
        bus_write(9'h1C, 32'h0000_0001);
        rd_chk(9'h10, "R2 clear lo");
        bus_write(9'h24, 32'h0000_0004);
        rd_chk(9'h18, "R2 clear loc");
        rd_chk(9'h1C, "R5 inverse lo");
        rd_chk(9'h24, "R5 inverse loc");

        // R3/R4: pending and summary with all lines active
        @(negedge clk);
        plvl = '1; llvl = '1;
        rd_chk(9'h04, "R3 pend lo");
        rd_chk(9'h08, "R3 pend hi");
        bus_write(9'h10, 32'hFFFF_FFFF);
        bus_write(9'h14, 32'hFFFF_FFFF);
        rd_chk(9'h00, "R4 summary all");
        bus_write(9'h20, 32'hFFFF_FFFF);
        rd_chk(9'h00, "R4 summary no hi");
        check_outputs("R8 all");

        // R7: FIQ ignores masks
        bus_write(9'h1C, 32'hFFFF_FFFF);
        bus_write(9'h24, 32'hFF);
        @(negedge clk);
        plvl = 64'h0000_0000_0000_0020; llvl = 8'h04;
        bus_write(9'h0C, 32'h0000_0085);
        rd_chk(9'h0C, "R6 fiq ctrl");
        check_outputs("R7 sel5 masked");
        bus_write(9'h0C, 32'h0000_00C2);
        check_outputs("R7 sel local2");
        bus_write(9'h0C, 32'h0000_00E4);
        @(negedge clk);
        plvl = '1; llvl = '1;
        check_outputs("R7 sel100 dead");
        bus_write(9'h0C, 32'h0000_0005);
        check_outputs("R7 disabled");

        // R9: one-edge latency
        @(negedge clk);
        plvl = '0; llvl = '0;
        bus_write(9'h10, 32'h0000_0001);
        check_outputs("R9 settle");
        @(negedge clk);
        plvl[0] = 1'b1;
        #1;
        chk("R9 irq before edge", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq after edge", {31'h0, irq}, 32'h1);

        // R11: holes
        bus_write(9'h28, 32'hFFFF_FFFF);
        bus_write(9'h1FC, 32'hFFFF_FFFF);
        bus_write(9'h11, 32'hFFFF_FFFF);
        bus_write(9'h1E, 32'hFFFF_FFFF);
        rd_chk(9'h28, "R11 hole read");
        rd_chk(9'h12, "R11 unaligned read");
        check_all_regs();

        // Random traffic
        for (int it = 0; it < 300; it++) begin
            @(negedge clk);
            plvl = {$urandom, $urandom};
            llvl = 8'($urandom);
            for (int w = 0; w < 3; w++) begin
                if (($urandom % 8) == 0) a = 9'($urandom);
                else a = 9'(($urandom % 10) * 4);
                d = $urandom;
                if (a == 9'h0C && ($urandom % 2) == 0) d[6:0] = 7'($urandom % 72);
                bus_write(a, d);
            end
            check_all_regs();
            rd_chk(9'($urandom), "R11 random read");
            check_outputs("R8 R7 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule